// File: doc/BRIEF.md
# Ethernet Receive Fast-Path Classifier

This block watches received Ethernet frames as they stream past, one 32-bit word per beat. It checks the start of each frame against expected header values: the destination MAC, the source MAC, the ethertype, a 16-bit flags field and a 16-bit sequence number. It then gives one verdict per frame. A frame whose header matches on every field is fast path, and hardware can deal with it. Any frame that fails a comparison, or that ends before its header is complete, is slow path and goes to firmware. After each fast-path verdict the expected sequence number steps forward by one, so a stream of in-order frames keeps matching.

The expected values sit in write-only configuration registers. The block does not buffer the frame. It only observes the stream, so its input handshake never applies back-pressure. The word layout within the header is fixed. Word 0 holds destination bytes 0 to 3, with byte 0 in bits 31:24. Word 1 holds destination bytes 4 and 5, then source bytes 0 and 1. Word 2 holds source bytes 2 to 5. Word 3 carries the ethertype in bits 31:16, and bits 15:0 are padding. Word 4 carries the flags in bits 31:16 and the sequence number in bits 15:0.

Top module: `eth_fastpath_classifier`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `verdict_valid` is 0 and `seq_expected` is 0. `in_ready` is 0 during reset and 1 from the first cycle after reset onward.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the register selected by `cfg_addr`:
  - 0: destination bytes 0 to 3.
  - 1: destination bytes 4 and 5 in bits 31:16, source bytes 0 and 1 in bits 15:0.
  - 2: source bytes 2 to 5.
  - 3: ethertype, taken from bits 31:16.
  - 4: flags, taken from bits 15:0.
  - 5: expected sequence number, taken from bits 15:0.
- R3: A frame is fast path when all five header words match the registers: words 0 to 2 in full, the upper half of word 3, and both halves of word 4. The fast-path verdict is `verdict_valid`=1 with `verdict_fast`=1.
- R4: A mismatch in any one field gives a slow-path verdict (`verdict_fast`=0). The fields are destination, source, ethertype, flags and sequence number. Bits 15:0 of word 3 never affect the verdict.
- R5: For a frame of five or more words, the verdict is a single-cycle strobe in the cycle after the fifth word is accepted. Words after the fifth word produce no further verdict.
- R6: A frame whose end-of-frame beat arrives before its fifth word (a runt) gives one slow-path verdict in the cycle after that beat. This includes a single-word frame with start and end on the same beat.
- R7: A fast-path verdict increments `seq_expected` by one, modulo 2^16, in the same cycle as the strobe. A slow-path verdict leaves it unchanged.
- R8: A write to register 5 in the same cycle as an increment takes priority. `seq_expected` takes the written value.
- R9: The block ignores these beats:
  - cycles with `in_valid` low;
  - beats that arrive outside a frame without `in_sof`.

  A beat with `in_sof` in the middle of a frame abandons the old frame without a verdict and starts a new frame at word 0.
- R10: A beat is accepted when `in_valid` and `in_ready` are both high. After reset, `in_ready` stays high, so the block never stalls its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream ready; high after reset |
| in_sof | input | 1 | Beat is the first word of a frame |
| in_eof | input | 1 | Beat is the last word of a frame |
| in_data | input | DATA_W | Stream word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register select |
| cfg_wdata | input | DATA_W | Configuration write data |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_fast | output | 1 | 1 = fast path, 0 = slow path; meaningful with `verdict_valid` |
| seq_expected | output | 16 | Current expected sequence number |

## Verification
The bench builds the block with its default parameters: a 32-bit word and a 3-bit register select. With these, the five-word header and all six configuration registers are reachable.

The 16-bit sequence field means the wrap from 0xFFFF to 0 can be tested directly by loading 0xFFFF and sending one matching frame. The fixed five-word header lets the bench cover:
- runts of one and three words;
- an exactly five-word frame;
- long frames with trailing words;
- a configuration write that lands on the same edge as the fifth word.

// File: rtl/eth_fpc_pkg.sv
package eth_fpc_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned HALF_W    = 16;
  localparam int unsigned HDR_WORDS = 5;
  localparam int unsigned HDR_IDX_W = $clog2(HDR_WORDS);
  localparam int unsigned CFG_AW    = 3;

  // register select codes
  localparam logic [CFG_AW-1:0] SEL_DST_HI = 3'd0;
  localparam logic [CFG_AW-1:0] SEL_MIXED  = 3'd1;
  localparam logic [CFG_AW-1:0] SEL_SRC_LO = 3'd2;
  localparam logic [CFG_AW-1:0] SEL_ETYPE  = 3'd3;
  localparam logic [CFG_AW-1:0] SEL_FLAGS  = 3'd4;
  localparam logic [CFG_AW-1:0] SEL_SEQ    = 3'd5;

  typedef struct packed {
    logic [WORD_W-1:0] dst_hi;
    logic [WORD_W-1:0] mixed;
    logic [WORD_W-1:0] src_lo;
    logic [HALF_W-1:0] etype;
    logic [HALF_W-1:0] flags;
    logic [HALF_W-1:0] seq;
  } match_cfg_t;

  // expected content of header word k
  function automatic logic [WORD_W-1:0] hdr_expect(match_cfg_t c, int unsigned k);
    case (k)
      0:       hdr_expect = c.dst_hi;
      1:       hdr_expect = c.mixed;
      2:       hdr_expect = c.src_lo;
      3:       hdr_expect = {c.etype, {HALF_W{1'b0}}};
      default: hdr_expect = {c.flags, c.seq};
    endcase
  endfunction

  // bits of header word k that take part in the comparison
  function automatic logic [WORD_W-1:0] hdr_mask(int unsigned k);
    if (k == 3) hdr_mask = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
    else        hdr_mask = {WORD_W{1'b1}};
  endfunction

endpackage

// File: rtl/eth_fpc_cfg.sv
module eth_fpc_cfg
  import eth_fpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              seq_inc,
  output match_cfg_t        cfg
);

  match_cfg_t cfg_q;
  logic       seq_wr;

  assign seq_wr = we && (addr == SEL_SEQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else begin
      if (we) begin
        case (addr)
          SEL_DST_HI: cfg_q.dst_hi <= wdata;
          SEL_MIXED:  cfg_q.mixed  <= wdata;
          SEL_SRC_LO: cfg_q.src_lo <= wdata;
          SEL_ETYPE:  cfg_q.etype  <= wdata[WORD_W-1 -: HALF_W];
          SEL_FLAGS:  cfg_q.flags  <= wdata[HALF_W-1:0];
          default: ;
        endcase
      end
      // a direct load wins over the step
      if (seq_wr)       cfg_q.seq <= wdata[HALF_W-1:0];
      else if (seq_inc) cfg_q.seq <= cfg_q.seq + 1'b1;
    end
  end

  assign cfg = cfg_q;

  AST_SEQ_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    seq_wr |=> (cfg_q.seq == $past(wdata[HALF_W-1:0]))); // R8

  AST_ETYPE_UPPER: assert property (@(posedge clk) disable iff (rst)
    (we && addr == SEL_ETYPE) |=> (cfg_q.etype == $past(wdata[WORD_W-1 -: HALF_W]))); // R2

endmodule

// File: rtl/eth_fpc_cmp.sv
module eth_fpc_cmp
  import eth_fpc_pkg::*;
(
  input  match_cfg_t           cfg,
  input  logic [HDR_IDX_W-1:0] idx,
  input  logic [WORD_W-1:0]    data,
  output logic                 ok
);

  logic [WORD_W-1:0] exp_w [HDR_WORDS];
  logic [WORD_W-1:0] msk_w [HDR_WORDS];
  logic [HDR_WORDS-1:0] hit;

  for (genvar k = 0; k < HDR_WORDS; k++) begin : g_word
    assign exp_w[k] = hdr_expect(cfg, k);
    assign msk_w[k] = hdr_mask(k);
    assign hit[k]   = ((data ^ exp_w[k]) & msk_w[k]) == '0;
  end

  always_comb begin
    ok = 1'b0;
    for (int k = 0; k < HDR_WORDS; k++) begin
      if (idx == HDR_IDX_W'(k)) ok = hit[k];
    end
  end

endmodule

// File: rtl/eth_fpc_track.sv
module eth_fpc_track
  import eth_fpc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 beat,
  input  logic                 sof,
  input  logic                 eof,
  input  logic                 ok,
  output logic [HDR_IDX_W-1:0] cmp_idx,
  output logic                 seq_inc,
  output logic                 verdict_valid,
  output logic                 verdict_fast
);

  localparam logic [HDR_IDX_W-1:0] LAST_IDX = HDR_IDX_W'(HDR_WORDS - 1);

  logic                 in_frame_q;
  logic                 miss_q;
  logic [HDR_IDX_W-1:0] idx_q;
  logic                 vld_q, fast_q;
  logic                 active, miss_n, last_hdr, runt_end;

  always_comb begin
    cmp_idx  = sof ? '0 : idx_q;
    active   = beat && (sof || in_frame_q);
    miss_n   = (sof ? 1'b0 : miss_q) | ~ok;
    last_hdr = active && (cmp_idx == LAST_IDX);
    runt_end = active && eof && !last_hdr;
    seq_inc  = last_hdr && !miss_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      miss_q     <= 1'b0;
      idx_q      <= '0;
      vld_q      <= 1'b0;
      fast_q     <= 1'b0;
    end else begin
      vld_q  <= last_hdr || runt_end;
      fast_q <= seq_inc;
      if (active) begin
        if (last_hdr || eof) begin
          in_frame_q <= 1'b0;
          idx_q      <= '0;
        end else begin
          in_frame_q <= 1'b1;
          idx_q      <= cmp_idx + 1'b1;
          miss_q     <= miss_n;
        end
      end
    end
  end

  assign verdict_valid = vld_q;
  assign verdict_fast  = fast_q;

  AST_RUNT_SLOW: assert property (@(posedge clk) disable iff (rst)
    (beat && eof && !sof && in_frame_q && idx_q < LAST_IDX) |=> (verdict_valid && !verdict_fast)); // R6

  AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!beat || (!sof && !in_frame_q)) |=> !verdict_valid); // R9

  AST_MISS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (beat && !sof && in_frame_q && miss_q && idx_q == LAST_IDX) |=> !verdict_fast); // R4

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx_q <= LAST_IDX); // R5

  AST_FAST_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    verdict_fast |-> verdict_valid); // R3

endmodule

// File: rtl/eth_fastpath_classifier.sv
module eth_fastpath_classifier #(
  parameter int unsigned DATA_W = eth_fpc_pkg::WORD_W,
  parameter int unsigned CFG_AW = eth_fpc_pkg::CFG_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [DATA_W-1:0] in_data,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              verdict_valid,
  output logic              verdict_fast,
  output logic [15:0]       seq_expected
);
  import eth_fpc_pkg::*;

  match_cfg_t           cfg;
  logic [HDR_IDX_W-1:0] cmp_idx;
  logic                 word_ok, seq_inc, beat, ready_q, seq_wr;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign beat     = in_valid && ready_q;
  assign seq_wr   = cfg_we && (cfg_addr == SEL_SEQ);

  eth_fpc_cfg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .seq_inc (seq_inc),
    .cfg     (cfg)
  );

  eth_fpc_cmp u_cmp (
    .cfg  (cfg),
    .idx  (cmp_idx),
    .data (in_data),
    .ok   (word_ok)
  );

  eth_fpc_track u_track (
    .clk           (clk),
    .rst           (rst),
    .beat          (beat),
    .sof           (in_sof),
    .eof           (in_eof),
    .ok            (word_ok),
    .cmp_idx       (cmp_idx),
    .seq_inc       (seq_inc),
    .verdict_valid (verdict_valid),
    .verdict_fast  (verdict_fast)
  );

  assign seq_expected = cfg.seq;

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (verdict_valid && verdict_fast && !$past(seq_wr)) |->
      (seq_expected == 16'($past(seq_expected) + 16'd1))); // R7

  AST_SEQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(verdict_valid && verdict_fast) && !$past(seq_wr)) |-> $stable(seq_expected)); // R7

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> in_ready); // R10

endmodule

// File: tb/eth_fastpath_classifier_tb_top.sv
module eth_fastpath_classifier_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [31:0] in_data = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        in_ready, verdict_valid, verdict_fast;
  logic [15:0] seq_expected;

  int unsigned n_checks = 0;
  int unsigned n_fails  = 0;

  always #5 clk = ~clk;

  eth_fastpath_classifier dut_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .verdict_valid(verdict_valid), .verdict_fast(verdict_fast),
    .seq_expected(seq_expected)
  );

  // reference state
  logic [47:0] m_dst, m_src;
  logic [15:0] m_type, m_flags, m_seq;

  // scoreboard
  bit          q_fast[$];
  logic [15:0] q_seq[$];
  string       q_tag[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && verdict_valid) begin
      if (q_fast.size() == 0) begin
        n_checks++; n_fails++;
        $display("FAIL R5/R9 unexpected verdict: actual fast=%0d expected none", verdict_fast);
      end else begin
        automatic bit    ef = q_fast.pop_front();
        automatic logic [15:0] es = q_seq.pop_front();
        automatic string t = q_tag.pop_front();
        check({t, " verdict"}, {31'd0, verdict_fast}, {31'd0, ef});
        check({t, " seq"}, {16'd0, seq_expected}, {16'd0, es});
      end
    end
  end

  task automatic cfg_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic program_all();
    cfg_write(3'd0, m_dst[47:16]);
    cfg_write(3'd1, {m_dst[15:0], m_src[47:32]});
    cfg_write(3'd2, m_src[31:0]);
    cfg_write(3'd3, {m_type, 16'h5A5A});   // low half must be dropped
    cfg_write(3'd4, {16'hFFFF, m_flags});  // high half must be dropped
    cfg_write(3'd5, {16'h0, m_seq});
  endtask

  // send one frame and queue its expected verdict
  task automatic send_frame(string tag, logic [47:0] dst, logic [47:0] src,
                            logic [15:0] et, logic [15:0] fl, logic [15:0] sq,
                            int nwords, bit gaps, logic [15:0] pad,
                            bit wr_last, logic [15:0] wr_val);
    logic [31:0] w [5];
    bit match;
    logic [15:0] seq_after;
    w[0] = dst[47:16];
    w[1] = {dst[15:0], src[47:32]};
    w[2] = src[31:0];
    w[3] = {et, pad};
    w[4] = {fl, sq};
    match = (dst == m_dst) && (src == m_src) && (et == m_type) && (fl == m_flags) && (sq == m_seq);
    if (nwords < 5) begin
      q_fast.push_back(1'b0); q_seq.push_back(m_seq); q_tag.push_back(tag);
    end else begin
      if (wr_last)    seq_after = wr_val;
      else if (match) seq_after = m_seq + 16'd1;
      else            seq_after = m_seq;
      q_fast.push_back(match); q_seq.push_back(seq_after); q_tag.push_back(tag);
      m_seq = seq_after;
    end
    for (int i = 0; i < nwords; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == nwords - 1);
      in_data  = (i < 5) ? w[i] : 32'hDEAD_0000 + i;
      cfg_we   = wr_last && (i == 4);
      cfg_addr = 3'd5;
      cfg_wdata = {16'h0, wr_val};
      if (gaps && i != nwords - 1) begin
        @(negedge clk);
        in_valid = 1'b0; in_data = 32'hFFFF_FFFF; cfg_we = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic good(string tag, int nwords, bit gaps);
    send_frame(tag, m_dst, m_src, m_type, m_flags, m_seq, nwords, gaps, 16'h0, 1'b0, 16'h0);
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    m_dst = 48'h02_11_22_33_44_55;
    m_src = 48'h0A_BB_CC_DD_EE_FF;
    m_type = 16'h88B5; m_flags = 16'h00A5; m_seq = 16'h0010;

    repeat (3) @(negedge clk);
    check("R1 ready in reset", {31'd0, in_ready}, 32'd0);
    check("R1 verdict in reset", {31'd0, verdict_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 seq after reset", {16'd0, seq_expected}, 32'd0);
    check("R1 verdict after reset", {31'd0, verdict_valid}, 32'd0);
    check("R10 ready after reset", {31'd0, in_ready}, 32'd1);

    program_all();
    check("R2 seq load", {16'd0, seq_expected}, {16'd0, m_seq});

    good("R3 long frame", 8, 1'b0); drain();
    good("R3 R10 frame with gaps", 7, 1'b1); drain();
    send_frame("R7 stale seq slow", m_dst, m_src, m_type, m_flags, m_seq - 16'd1, 6, 1'b0, 16'h0, 1'b0, 16'h0); drain();
    send_frame("R4 dst mismatch", m_dst ^ 48'h1, m_src, m_type, m_flags, m_seq, 6, 1'b0, 16'h0, 1'b0, 16'h0); drain();
    send_frame("R4 src mismatch", m_dst, m_src ^ 48'h8000_0000_0000, m_type, m_flags, m_seq, 6, 1'b0, 16'h0, 1'b0, 16'h0); drain();
    send_frame("R4 type mismatch", m_dst, m_src, 16'h0800, m_flags, m_seq, 6, 1'b0, 16'h0, 1'b0, 16'h0); drain();
    send_frame("R4 flags mismatch", m_dst, m_src, m_type, 16'h00A4, m_seq, 6, 1'b0, 16'h0, 1'b0, 16'h0); drain();
    send_frame("R4 pad ignored", m_dst, m_src, m_type, m_flags, m_seq, 6, 1'b0, 16'hBEEF, 1'b0, 16'h0); drain();
    good("R5 exact header frame", 5, 1'b0); drain();
    good("R6 runt three words", 3, 1'b0); drain();
    good("R6 runt one word", 1, 1'b0); drain();

    // R9 stray beats outside a frame
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 3);
      in_data = (i == 0) ? m_dst[47:16] : 32'h1234_0000 + i;
    end
    @(negedge clk); in_valid = 1'b0; in_eof = 1'b0;
    drain();
    check("R9 stray beats no verdict", q_fast.size(), 32'd0);
    check("R9 stray beats seq kept", {16'd0, seq_expected}, {16'd0, m_seq});

    // R9 restart: two words of a frame, then a new start
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = (i == 0); in_eof = 1'b0; in_data = 32'hAAAA_0000 + i;
    end
    good("R9 restart mid frame", 6, 1'b0); drain();

    // R7 wrap
    m_seq = 16'hFFFF;
    cfg_write(3'd5, 32'h0000_FFFF);
    good("R7 wrap", 5, 1'b0); drain();
    check("R7 wrapped to zero", {16'd0, seq_expected}, 32'd0);

    // R8 write on the increment edge
    send_frame("R8 write beats step", m_dst, m_src, m_type, m_flags, m_seq, 6, 1'b0, 16'h0, 1'b1, 16'h0100);
    drain();
    good("R8 after load", 5, 1'b0); drain();

    check("R5 all verdicts seen", q_fast.size(), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule